// File: doc/BRIEF.md
# Debug-Board Interrupt Expander

This block collects up to sixteen peripheral interrupt requests on a debug board, such as the request line of an Ethernet controller. It turns each request into a sticky pending bit. Every raw request first passes through a two-stage synchroniser. A rising edge of the synchronised level then sets the matching pending bit. The bit stays set until the host clears it. A per-source mask decides which pending bits reach the host. All enabled pending bits are ORed onto a single active-low, level-sensitive request line.

The host reaches the block over a simple 16-bit register bus. Writes are qualified by a select and a write strobe. Read data is a combinational function of the address. The host services the block in a fixed order: read the mask and the pending bits, and service each bit set in `pending & ~mask`, where bit 0 is source 0. To clear pending bits, write ones to a separate clear register, then write it back to zero. Three fixed signature words let the host confirm that the board is fitted before it touches anything else. A version word reports the logic revision.

Top module: `dbgx_expander`

## Requirements
- R1: Register map by byte address, with `bus_addr[0]` ignored: 0x0 mask (read/write), 0x2 pending (read only), 0x4 clear (read/write), 0x6, 0x8 and 0xA signature words, 0xC version. Address 0xE reads 0x0000. `bus_rdata` follows `bus_addr` in the same cycle.
- R2: After a synchronous active-low reset, the mask reads 0xFFFF, the pending and clear registers read 0x0000, and `host_irq_n` is 1.
- R3: When `irq_raw[n]` goes from 0 to 1 ahead of clock edge k, pending bit n reads 1 after edge k+2 and still reads 0 after edge k+1. An input that stays high sets its bit only once per rising edge.
- R4: A pending bit stays set until clear bit n is written as 1. It reads 0 one edge later. It cannot be set again while clear bit n remains 1. Other pending bits are unaffected.
- R5: Writing 0xFFFF and then 0x0000 to the clear register leaves every pending bit at 0.
- R6: `host_irq_n` is 0 exactly when some bit n has pending=1 and mask=0. A mask bit of 1 blocks its source.
- R7: A masked source still sets its pending bit.
- R8: The signature words at 0x6, 0x8 and 0xA always read 0xAAAA, 0x5555 and 0xCAFE.
- R9: The version word at 0xC reads the parameter `VERSION` (default 0x0102).
- R10: Writes to the pending, signature, version or unmapped addresses change no register.
- R11: The start-up sequence runs as follows: mask 0x0000, clear 0xFFFF, clear 0x0000, mask 0x001F. After it, pending reads 0, mask reads 0x001F and `host_irq_n` is 1. Sources 0 to 4 stay blocked and sources 5 to 15 are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_raw | input | 16 | Asynchronous peripheral requests, active high |
| bus_sel | input | 1 | Register bus select |
| bus_we | input | 1 | Write strobe, used with `bus_sel` |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| host_irq_n | output | 1 | Combined request to host, active low, level |

## Verification
The hardest case to reach is a rising edge that lands while its clear bit is still held at one. The edge must be lost and must not reappear after the clear is released. The bench writes the clear bit first and leaves it at one. It pulses the source for several cycles, waits past the synchroniser delay, then releases the clear and reads the pending register. A source held high across a clear is also covered, which shows that a level alone does not set the bit again.

// File: rtl/dbgx_pkg.sv
// Shared constants for the debug-board interrupt expander.
// Assumes a 16-bit register bus addressed in bytes, with word-aligned registers.
package dbgx_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 4;

    // Word index decoded from bus_addr[3:1]
    typedef enum logic [2:0] {
        SEL_MASK = 3'd0,
        SEL_PEND = 3'd1,
        SEL_CLR  = 3'd2,
        SEL_SIG0 = 3'd3,
        SEL_SIG1 = 3'd4,
        SEL_SIG2 = 3'd5,
        SEL_VER  = 3'd6,
        SEL_NONE = 3'd7
    } reg_sel_e;

    localparam logic [DATA_W-1:0] SIG_WORD0 = 16'hAAAA;
    localparam logic [DATA_W-1:0] SIG_WORD1 = 16'h5555;
    localparam logic [DATA_W-1:0] SIG_WORD2 = 16'hCAFE;
    localparam logic [DATA_W-1:0] MASK_RST  = 16'hFFFF;
endpackage

// File: rtl/dbgx_sync.sv
// Multi-stage level synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; no bus coherency is implied across bits.
module dbgx_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage captures the raw inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                // Later stages shift the sample along
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/dbgx_pending.sv
// Rising-edge detector and sticky pending bits.
// Assumes clr holds a bit at zero and blocks new sets while that clr bit is 1.
module dbgx_pending #(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] sync_lvl,
    input  logic [N_SRC-1:0] clr,
    output logic [N_SRC-1:0] pend_q
);
    logic [N_SRC-1:0] lvl_d;
    logic [N_SRC-1:0] edge_hit;

    // Remember the previous synchronised level
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= '0;
        else        lvl_d <= sync_lvl;
    end

    // Low-to-high transitions of the synchronised level
    always_comb edge_hit = sync_lvl & ~lvl_d;

    // Set on edge, hold, clear wins over set
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q | edge_hit) & ~clr;
    end
endmodule

// File: rtl/dbgx_regs.sv
// Host register file: mask and clear storage plus the read multiplexer.
// Assumes writes take one clock; reads are combinational from bus_addr.
module dbgx_regs
    import dbgx_pkg::*;
#(
    parameter int                N_SRC   = 16,
    parameter logic [DATA_W-1:0] VERSION = 16'h0102
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N_SRC-1:0]  pend,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] clr_q,
    output logic [DATA_W-1:0] rdata
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] pend_w;

    // Decode the word index, ignoring the byte-lane bit
    always_comb sel = reg_sel_e'(addr[ADDR_W-1:1]);

    // Widen the pending vector to the bus width
    always_comb begin
        pend_w              = '0;
        pend_w[N_SRC-1:0]   = pend;
    end

    // Writable registers: mask and clear only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= MASK_RST;
            clr_q  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_MASK: mask_q <= wdata;
                SEL_CLR:  clr_q  <= wdata;
                default:  ;
            endcase
        end
    end

    // Read multiplexer
    always_comb begin
        case (sel)
            SEL_MASK: rdata = mask_q;
            SEL_PEND: rdata = pend_w;
            SEL_CLR:  rdata = clr_q;
            SEL_SIG0: rdata = SIG_WORD0;
            SEL_SIG1: rdata = SIG_WORD1;
            SEL_SIG2: rdata = SIG_WORD2;
            SEL_VER:  rdata = VERSION;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/dbgx_expander.sv
// Top level of the debug-board interrupt expander.
// Assumes irq_raw is asynchronous and active high; host_irq_n is a level output.
module dbgx_expander
    import dbgx_pkg::*;
#(
    parameter int                N_SRC     = 16,
    parameter int                SYNC_STGS = 2,
    parameter logic [DATA_W-1:0] VERSION   = 16'h0102
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       irq_raw,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [3:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              host_irq_n
);
    logic [N_SRC-1:0]  sync_lvl;
    logic [N_SRC-1:0]  status_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] clr_q;
    logic              wr_en;

    // Qualify the write strobe
    always_comb wr_en = bus_sel & bus_we;

    dbgx_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STGS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_raw[N_SRC-1:0]),
        .sync_out (sync_lvl)
    );

    dbgx_pending #(.N_SRC(N_SRC)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_lvl (sync_lvl),
        .clr      (clr_q[N_SRC-1:0]),
        .pend_q   (status_q)
    );

    dbgx_regs #(.N_SRC(N_SRC), .VERSION(VERSION)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .pend   (status_q),
        .mask_q (mask_q),
        .clr_q  (clr_q),
        .rdata  (bus_rdata)
    );

    // Combine enabled pending bits onto the active-low host line
    always_comb host_irq_n = ~|(status_q & ~mask_q[N_SRC-1:0]);
endmodule

// File: rtl/dbgx_checker.sv
// Property checker for dbgx_expander, attached through bind.
// Assumes the internal names sync_lvl, status_q, mask_q and clr_q in the top.
module dbgx_checker #(
    parameter int N_SRC = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] sync_lvl,
    input logic [N_SRC-1:0] status_q,
    input logic [15:0]      mask_q,
    input logic [15:0]      clr_q,
    input logic [3:0]       bus_addr,
    input logic [15:0]      bus_rdata,
    input logic             host_irq_n
);
    assert_set_needs_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((status_q & ~$past(status_q) & ~$past(sync_lvl)) == '0));

    assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_q) |=> ((status_q & $past(clr_q[N_SRC-1:0])) == '0));

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|status_q) |=> (($past(status_q) & ~status_q & ~$past(clr_q[N_SRC-1:0])) == '0));

    assert_all_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 16'hFFFF) |-> host_irq_n);

    assert_signature0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[3:1] == 3'd3) |-> (bus_rdata == 16'hAAAA));
endmodule

bind dbgx_expander dbgx_checker #(.N_SRC(N_SRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_lvl   (sync_lvl),
    .status_q   (status_q),
    .mask_q     (mask_q),
    .clr_q      (clr_q),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .host_irq_n (host_irq_n)
);

// File: tb/sim_dbgx_expander.sv
// Bench for dbgx_expander: behavioural model compared every clock plus directed checks.
module sim_dbgx_expander;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_raw = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        host_irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    dbgx_expander u0 (
        .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_irq_n(host_irq_n)
    );

    // Behavioural model: raw history queue, pending, mask, clear
    logic [15:0] m_mask, m_pend, m_clr, m_rise;
    logic [15:0] hist [$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = 16'hFFFF; m_pend = '0; m_clr = '0;
            hist = '{16'h0, 16'h0, 16'h0};
        end else begin
            m_rise = hist[1] & ~hist[2];
            m_pend = (m_pend | m_rise) & ~m_clr;
            if (bus_sel && bus_we) begin
                if (bus_addr[3:1] == 3'd0) m_mask = bus_wdata;
                if (bus_addr[3:1] == 3'd2) m_clr  = bus_wdata;
            end
            hist.push_front(irq_raw);
            void'(hist.pop_back());
        end
    end

    function automatic logic [15:0] model_read(input logic [3:0] a);
        case (a[3:1])
            3'd0: return m_mask;
            3'd1: return m_pend;
            3'd2: return m_clr;
            3'd3: return 16'hAAAA;
            3'd4: return 16'h5555;
            3'd5: return 16'hCAFE;
            3'd6: return 16'h0102;
            default: return 16'h0000;
        endcase
    endfunction

    // Per-clock comparison against the model (R1 read path, R6 host line)
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            checks++;
            if (bus_rdata !== model_read(bus_addr)) begin
                fails++;
                $display("FAIL R1 rdata addr=%h actual=%h expected=%h", bus_addr, bus_rdata, model_read(bus_addr));
            end
            checks++;
            if (host_irq_n !== ~|(m_pend & ~m_mask)) begin
                fails++;
                $display("FAIL R6 host_irq_n actual=%b expected=%b", host_irq_n, ~|(m_pend & ~m_mask));
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_addr = a;
        @(posedge clk);
        #5;
        d = bus_rdata;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R2 reset state
        rd(4'h0, v); chk("R2 mask after reset", v, 16'hFFFF);
        rd(4'h2, v); chk("R2 pending after reset", v, 16'h0000);
        rd(4'h4, v); chk("R2 clear after reset", v, 16'h0000);
        chk("R2 host_irq_n after reset", {15'd0, host_irq_n}, 16'h0001);

        // R8 signatures, R9 version, R1 unmapped and odd byte address
        rd(4'h6, v); chk("R8 signature 0", v, 16'hAAAA);
        rd(4'h8, v); chk("R8 signature 1", v, 16'h5555);
        rd(4'hA, v); chk("R8 signature 2", v, 16'hCAFE);
        rd(4'hC, v); chk("R9 version", v, 16'h0102);
        rd(4'hE, v); chk("R1 unmapped reads zero", v, 16'h0000);
        rd(4'h7, v); chk("R1 byte bit ignored", v, 16'hAAAA);

        // R11 start-up sequence
        wr(4'h0, 16'h0000);
        wr(4'h4, 16'hFFFF);
        wr(4'h4, 16'h0000);
        wr(4'h0, 16'h001F);
        rd(4'h0, v); chk("R11 mask after init", v, 16'h001F);
        rd(4'h2, v); chk("R11 pending after init", v, 16'h0000);
        chk("R11 host line idle", {15'd0, host_irq_n}, 16'h0001);

        // R3 latency and R7 masked source latches
        @(negedge clk); bus_addr = 4'h2; irq_raw[0] = 1'b1;
        @(posedge clk); @(posedge clk); #5;
        chk("R3 pending not yet set after edge k+1", bus_rdata, 16'h0000);
        @(posedge clk); #5;
        chk("R3 pending set after edge k+2", bus_rdata, 16'h0001);
        chk("R7 masked source keeps host line idle", {15'd0, host_irq_n}, 16'h0001);
        @(negedge clk); irq_raw[0] = 1'b0;

        // R6 enabled source drives host line
        @(negedge clk); irq_raw[5] = 1'b1;
        repeat (4) @(posedge clk);
        rd(4'h2, v); chk("R6 pending with source 5", v, 16'h0021);
        chk("R6 host line asserted", {15'd0, host_irq_n}, 16'h0000);
        wr(4'h0, 16'h003F);
        rd(4'h0, v); chk("R6 masking releases host line", {15'd0, host_irq_n}, 16'h0001);
        wr(4'h0, 16'h001F);
        rd(4'h0, v); chk("R6 unmasking reasserts host line", {15'd0, host_irq_n}, 16'h0000);

        // R3 held level does not re-set; R4 clear touches only its bit
        wr(4'h4, 16'h0020);
        wr(4'h4, 16'h0000);
        repeat (5) @(posedge clk);
        rd(4'h2, v); chk("R4 clear one bit, R3 level no reset", v, 16'h0001);
        chk("R4 host line released", {15'd0, host_irq_n}, 16'h0001);

        // R4 edge lost while clear bit is held
        wr(4'h4, 16'h0040);
        @(negedge clk); irq_raw[6] = 1'b1;
        repeat (3) @(negedge clk);
        irq_raw[6] = 1'b0;
        repeat (4) @(posedge clk);
        rd(4'h2, v); chk("R4 edge blocked during clear", v, 16'h0001);
        wr(4'h4, 16'h0000);
        repeat (4) @(posedge clk);
        rd(4'h2, v); chk("R4 blocked edge stays lost", v, 16'h0001);

        // R5 clear-all with several pending sources
        @(negedge clk); irq_raw[8] = 1'b1; irq_raw[15] = 1'b1;
        repeat (4) @(posedge clk);
        rd(4'h2, v); chk("R5 several pending", v, 16'h8101);
        wr(4'h0, 16'h0000);
        rd(4'h0, v); chk("R6 all enabled asserts", {15'd0, host_irq_n}, 16'h0000);
        wr(4'h4, 16'hFFFF);
        wr(4'h4, 16'h0000);
        rd(4'h2, v); chk("R5 all cleared", v, 16'h0000);
        chk("R5 host line idle", {15'd0, host_irq_n}, 16'h0001);

        // R10 read-only and unmapped writes
        wr(4'h2, 16'h1234);
        wr(4'h6, 16'h1234);
        wr(4'hC, 16'h1234);
        wr(4'hE, 16'h1234);
        rd(4'h2, v); chk("R10 pending unchanged", v, 16'h0000);
        rd(4'h6, v); chk("R10 signature unchanged", v, 16'hAAAA);
        rd(4'hC, v); chk("R10 version unchanged", v, 16'h0102);
        rd(4'h0, v); chk("R10 mask unchanged", v, 16'h0000);
        rd(4'h4, v); chk("R10 clear unchanged", v, 16'h0000);

        done = 1;
        summary();
        $finish;
    end
endmodule